// File: doc/BRIEF.md
# Configuration Command Controller

This block is a small command port that sits on a simple register bus. It has three registers. The data register holds an operand. Writing the control register issues a command at once. The status register reports whether the most recent command completed and whether it was recognised.

When a written command matches one of two fixed codes, the block raises a shutdown request or a reboot request for one clock. A power or reset manager elsewhere on the chip acts on that request. The command word is compared after two bits have been masked off, so a sender that sets those bits still reaches the same command.

The port only exists when the board-type input carries the enabling value 0x190. On any other board the three offsets act like unused addresses: they read as zero and writes to them are dropped. Reads are combinational from the current address, with no wait states.

Top module: `cfgcmd_ctrl`

## Requirements
- R1: After reset the data, control and status registers all read zero, and both request outputs are low.
- R2: At offset 0xA0 the data register stores all 32 bits written to it and returns them on read.
- R3: A write to offset 0xA4 stores the written word with bits 19:18 cleared, and a read of 0xA4 returns that stored word.
- R4: Every write to 0xA4 sets status bit 0 (complete). A recognised command leaves bit 1 (error) clear, so status reads 0b01. Any other value also sets bit 1, so status reads 0b11. The status is readable at 0xA8 in the cycle after the write.
- R5: A control write whose masked value equals 0xC0800000 drives shutdown_req high for exactly the one cycle after the write's clock edge. Because bits 19:18 are masked, 0xC08C0000 counts as the same command.
- R6: A control write whose masked value equals 0xC0900000 drives reboot_req high for exactly the one cycle after the write's clock edge. The two request outputs are never high together.
- R7: A write to offset 0xA8 stores only bits 1:0 of the written value, and all other status bits read zero.
- R8: When board_type is not 0x190, reads of 0xA0, 0xA4 and 0xA8 return zero. Writes to those offsets change no register and raise no request.
- R9: Offsets other than the three registers read zero, and writes to them change none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_type | input | 12 | Board identifier; the port is enabled when it equals 0x190 |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
On every cycle the assertions check several invariants:
- The stored command never has bits 19:18 set.
- A control write always leaves status bit 0 set, and an unrecognised command leaves status at 0b11.
- A request pulse appears only in the cycle after a control write, and the two requests are never high together.
- Every read returns zero while the board is disabled.

Only the bench scenarios can show three other behaviours:
- Writes made on a disabled board are truly dropped; this is shown by re-enabling the board and reading the registers back.
- The masked alias 0xC08C0000 still triggers a shutdown.
- Stray offsets leave the three registers untouched.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    CMD_OTHER    = 2'd0,
    CMD_SHUTDOWN = 2'd1,
    CMD_REBOOT   = 2'd2
  } cmd_kind_e;

  localparam logic [DATA_W-1:0] CMD_MASK      = 32'h000C_0000;
  localparam logic [DATA_W-1:0] CODE_SHUTDOWN = 32'hC080_0000;
  localparam logic [DATA_W-1:0] CODE_REBOOT   = 32'hC090_0000;

  function automatic logic [DATA_W-1:0] cmd_strip(input logic [DATA_W-1:0] v);
    return v & ~CMD_MASK;
  endfunction

  function automatic cmd_kind_e cmd_classify(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] s;
    s = cmd_strip(v);
    if (s == CODE_SHUTDOWN) return CMD_SHUTDOWN;
    if (s == CODE_REBOOT)   return CMD_REBOOT;
    return CMD_OTHER;
  endfunction

  function automatic logic [1:0] cmd_status(input cmd_kind_e k);
    return (k == CMD_OTHER) ? 2'b11 : 2'b01;
  endfunction
endpackage

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode #(
  parameter int ADDR_W = 12,
  parameter int BOARD_W = 12,
  parameter logic [BOARD_W-1:0] BOARD_ON = 12'h190,
  parameter logic [ADDR_W-1:0] OFS_DATA = 12'h0A0,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h0A4,
  parameter logic [ADDR_W-1:0] OFS_STAT = 12'h0A8
) (
  input  logic [BOARD_W-1:0] board_type,
  input  logic [ADDR_W-1:0]  addr,
  output logic               board_ok,
  output logic [2:0]         sel
);
  localparam int NREG = 3;
  logic [ADDR_W-1:0] ofs [NREG];
  assign ofs[0] = OFS_DATA;
  assign ofs[1] = OFS_CTRL;
  assign ofs[2] = OFS_STAT;

  assign board_ok = (board_type == BOARD_ON);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = board_ok && (addr == ofs[i]);
  end
endmodule

// File: rtl/cfgcmd_exec.sv
module cfgcmd_exec
  import cfgcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_ev,
  input  logic [DATA_W-1:0] wdata,
  output logic              shutdown_req,
  output logic              reboot_req
);
  cmd_kind_e kind;
  assign kind = cmd_classify(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      shutdown_req <= ctrl_wr_ev && (kind == CMD_SHUTDOWN);
      reboot_req   <= ctrl_wr_ev && (kind == CMD_REBOOT);
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req)); // R6
  AST_SHUT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ev && (cmd_strip(wdata) == CODE_SHUTDOWN) |=> shutdown_req); // R5
  AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reboot_req) |-> $past(ctrl_wr_ev)); // R6
endmodule

// File: rtl/cfgcmd_regs.sv
module cfgcmd_regs
  import cfgcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_wr_ev,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rd_ctrl,
  output logic [1:0]        rd_stat
);
  logic [DATA_W-1:0] data_q, ctrl_q;
  logic [1:0]        stat_q;

  assign ctrl_wr_ev = wr_en && sel[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else if (wr_en) begin
      if (sel[0]) data_q <= wdata;
      if (sel[1]) begin
        ctrl_q <= cmd_strip(wdata);
        stat_q <= cmd_status(cmd_classify(wdata));
      end else if (sel[2]) begin
        stat_q <= wdata[1:0];
      end
    end
  end

  assign rd_data = data_q;
  assign rd_ctrl = ctrl_q;
  assign rd_stat = stat_q;

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[19:18] == 2'b00); // R3
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ev |=> stat_q[0]); // R4
  AST_ERR_ON_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_ev && (cmd_strip(wdata) != CODE_SHUTDOWN) && (cmd_strip(wdata) != CODE_REBOOT)
    |=> stat_q == 2'b11); // R4
endmodule

// File: rtl/cfgcmd_ctrl.sv
module cfgcmd_ctrl
  import cfgcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BOARD_W = 12,
  parameter logic [BOARD_W-1:0] BOARD_ON = 12'h190
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BOARD_W-1:0] board_type,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               shutdown_req,
  output logic               reboot_req
);
  logic              board_ok;
  logic [2:0]        sel;
  logic              ctrl_wr_ev;
  logic [DATA_W-1:0] rd_data, rd_ctrl;
  logic [1:0]        rd_stat;

  cfgcmd_decode #(.ADDR_W(ADDR_W), .BOARD_W(BOARD_W), .BOARD_ON(BOARD_ON)) u_dec (
    .board_type(board_type), .addr(addr), .board_ok(board_ok), .sel(sel)
  );

  cfgcmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .ctrl_wr_ev(ctrl_wr_ev), .rd_data(rd_data), .rd_ctrl(rd_ctrl), .rd_stat(rd_stat)
  );

  cfgcmd_exec u_exec (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_ev(ctrl_wr_ev), .wdata(wdata),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  always_comb begin
    unique case (1'b1)
      sel[0]:  rdata = rd_data;
      sel[1]:  rdata = rd_ctrl;
      sel[2]:  rdata = {{(DATA_W-2){1'b0}}, rd_stat};
      default: rdata = '0;
    endcase
  end

  AST_OFF_BOARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !board_ok |-> rdata == '0); // R8
  AST_OFF_BOARD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !board_ok && wr_en |=> !shutdown_req && !reboot_req); // R8
endmodule

// File: tb/cfgcmd_ctrl_tb_top.sv
module cfgcmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] board_type = 12'h190;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        shutdown_req, reboot_req;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfgcmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .board_type(board_type), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .shutdown_req(shutdown_req), .reboot_req(reboot_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write: drive at negedge, capture at posedge, return 1 ns after it.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12'h0A0, v); check("R1 data", v, 0);
    rd(12'h0A4, v); check("R1 ctrl", v, 0);
    rd(12'h0A8, v); check("R1 stat", v, 0);
    check("R1 reqs", {30'd0, shutdown_req, reboot_req}, 0);
  endtask

  task automatic t_data;
    logic [31:0] v;
    wr(12'h0A0, 32'hDEAD_BEEF); rd(12'h0A0, v); check("R2 data1", v, 32'hDEAD_BEEF);
    wr(12'h0A0, 32'h0123_4567); rd(12'h0A0, v); check("R2 data2", v, 32'h0123_4567);
  endtask

  task automatic t_unknown_cmd;
    logic [31:0] v;
    wr(12'h0A4, 32'hFFFF_FFFF);
    check("R5 no shutdown on unknown", {31'd0, shutdown_req}, 0);
    check("R6 no reboot on unknown", {31'd0, reboot_req}, 0);
    rd(12'h0A4, v); check("R3 ctrl masked", v, 32'hFFF3_FFFF);
    rd(12'h0A8, v); check("R4 stat error", v, 32'h3);
  endtask

  task automatic t_status_write;
    logic [31:0] v;
    wr(12'h0A8, 32'hFFFF_FFFE); rd(12'h0A8, v); check("R7 stat low bits", v, 32'h2);
    wr(12'h0A8, 32'h0000_0000); rd(12'h0A8, v); check("R7 stat clear", v, 32'h0);
  endtask

  task automatic t_shutdown;
    logic [31:0] v;
    wr(12'h0A4, 32'hC08C_0000);
    check("R5 shutdown pulse", {30'd0, shutdown_req, reboot_req}, 32'h2);
    @(posedge clk); #1;
    check("R5 shutdown one cycle", {31'd0, shutdown_req}, 0);
    rd(12'h0A4, v); check("R3 ctrl alias", v, 32'hC080_0000);
    rd(12'h0A8, v); check("R4 stat done", v, 32'h1);
  endtask

  task automatic t_reboot;
    logic [31:0] v;
    wr(12'h0A4, 32'hC090_0000);
    check("R6 reboot pulse", {30'd0, shutdown_req, reboot_req}, 32'h1);
    @(posedge clk); #1;
    check("R6 reboot one cycle", {31'd0, reboot_req}, 0);
    rd(12'h0A8, v); check("R4 stat after reboot", v, 32'h1);
  endtask

  task automatic t_off_board;
    logic [31:0] v;
    wr(12'h0A0, 32'h5555_AAAA);
    board_type = 12'h182;
    rd(12'h0A0, v); check("R8 read zero off board", v, 0);
    wr(12'h0A0, 32'h1111_1111);
    wr(12'h0A4, 32'hC080_0000);
    check("R8 no request off board", {31'd0, shutdown_req}, 0);
    wr(12'h0A8, 32'h3);
    board_type = 12'h190;
    rd(12'h0A0, v); check("R8 data kept", v, 32'h5555_AAAA);
    rd(12'h0A4, v); check("R8 ctrl kept", v, 32'hC090_0000);
    rd(12'h0A8, v); check("R8 stat kept", v, 32'h1);
  endtask

  task automatic t_other_ofs;
    logic [31:0] v;
    wr(12'h0AC, 32'hFFFF_FFFF);
    wr(12'h09C, 32'hFFFF_FFFF);
    rd(12'h0AC, v); check("R9 stray read", v, 0);
    rd(12'h0A0, v); check("R9 data untouched", v, 32'h5555_AAAA);
    rd(12'h0A8, v); check("R9 stat untouched", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_data;
    t_unknown_cmd;
    t_status_write;
    t_shutdown;
    t_reboot;
    t_off_board;
    t_other_ofs;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule